// File: doc/BRIEF.md
# Exposure Shutter and Fast Line Dump Controller

This block adds exposure control and fast line removal to the timing generator of an interline CCD. It counts clock cycles from each frame sync pulse. The frame sync marks the clock edge that ends the photodiode transfer, which is the falling edge of phase-1. The block places one substrate shutter pulse in the frame so that the pulse ends a programmed number of cycles before the next frame sync. That interval is the exposure. When no shutter pulse is issued, the exposure is the whole frame.

On request, the block also runs a dump sequence. It discards a programmed number of lines through the fast dump gates, then asks for one normal readout line. For each discarded line, the dump gate of each selected half rises first. A guard interval later, the block requests a vertical shift from the vertical sequencer. The gate stays high for another guard interval after the shift has ended.

All outputs stay inactive while reset is asserted and while the protection bias is not reported stable. A loss of bias stops any dump sequence in progress.

Top module: `shutter_dump_ctrl`

## Requirements
- R1: When a pulse is issued, its last high cycle ends exactly `exp_len` clock cycles before the clock edge that samples the next `frame_sync`. With `exp_len` = 0, the last high cycle is the sync cycle itself. `frame_len` and `exp_len` are captured at each `frame_sync`. No pulse is issued before the first `frame_sync`.
- R2: Each shutter pulse is high for exactly `SHUT_W` consecutive cycles.
- R3: A pulse is issued only if `exp_len + SHUT_W + 1 <= frame_len`. Otherwise no pulse is issued for that frame, and the exposure is the full frame. At equality a full-width pulse is still issued.
- R4: `shutter` is low in every cycle where `bias_ok` is low. It is also low in the cycle right after a cycle where `bias_ok` was low.
- R5: Each discarded line works as follows. The dump gate of each selected half rises. Exactly `GAP` cycles later, `vshift_req` pulses for one cycle. The gate stays high for `2*GAP+VSH` cycles in total. The gate is then low for `GAP` cycles before the next line.
- R6: After the last discarded line, `read_line` pulses for exactly one cycle. With a dump count of 0, `read_line` pulses and no gate rises.
- R7: `dump_halves` is captured with `dump_go`. Bit 0 enables `fdg_bot` and bit 1 enables `fdg_top`. A half that is not selected keeps its gate low for the whole sequence.
- R8: Deasserting `bias_ok` during a dump drops both gates in that same cycle and abandons the sequence. No `read_line` pulse follows.
- R9: While `rst_n` is low, all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bias_ok | input | 1 | Protection bias reported stable |
| frame_sync | input | 1 | One-cycle pulse at the end of the photodiode transfer |
| frame_len | input | CW | Frame period in cycles |
| exp_len | input | CW | Requested exposure in cycles |
| dump_go | input | 1 | One-cycle request to start a dump sequence |
| dump_lines | input | NW | Number of lines to discard |
| dump_halves | input | 2 | Half select: bit 0 bottom, bit 1 top |
| shutter | output | 1 | Substrate shutter pulse |
| fdg_bot | output | 1 | Dump gate, bottom half |
| fdg_top | output | 1 | Dump gate, top half |
| vshift_req | output | 1 | One-cycle request for a vertical line shift |
| read_line | output | 1 | One-cycle request for the normal readout line |

## Verification
The hardest cases to reach are at the exposure limit. The pulse must still appear when `exp_len + SHUT_W + 1` equals the frame length, and it must vanish one cycle beyond that. A bias loss in the middle of a discarded line is also hard to reach. The bench drives a sync period that matches `frame_len` and sweeps the exposure through 0, a mid value, the last legal value and the first clamped value. For each frame it measures the pulse width and the distance from the pulse to the sync sample. For the abort case, it removes the bias at a chosen cycle inside the first line's gate window. It then confirms that the gates drop at once and that no readout request follows.

// File: rtl/shutter_dump_ctrl.sv
module shutter_dump_ctrl #(
  parameter int CW     = 24,
  parameter int NW     = 8,
  parameter int SHUT_W = 100,
  parameter int GAP    = 200,
  parameter int VSH    = 400
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bias_ok,
  input  logic          frame_sync,
  input  logic [CW-1:0] frame_len,
  input  logic [CW-1:0] exp_len,
  input  logic          dump_go,
  input  logic [NW-1:0] dump_lines,
  input  logic [1:0]    dump_halves,
  output logic          shutter,
  output logic          fdg_bot,
  output logic          fdg_top,
  output logic          vshift_req,
  output logic          read_line
);
  localparam int TMAX = (GAP > VSH) ? GAP : VSH;
  localparam int TW   = $clog2(TMAX + 1);

  // exposure timing
  logic [CW-1:0] cnt, win_lo, win_hi;
  logic          armed, shut_q;
  logic [CW:0]   need;

  assign need = {1'b0, exp_len} + (CW+1)'(SHUT_W + 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      win_lo <= '0;
      win_hi <= '0;
      armed  <= 1'b0;
      shut_q <= 1'b0;
    end else begin
      shut_q <= armed && bias_ok && (cnt >= win_lo) && (cnt < win_hi);
      if (frame_sync) begin
        cnt    <= '0;
        armed  <= (need <= {1'b0, frame_len});
        win_hi <= frame_len - exp_len - CW'(1);
        win_lo <= frame_len - exp_len - CW'(SHUT_W + 1);
      end else if (!(&cnt)) begin
        cnt <= cnt + CW'(1);
      end
    end
  end

  assign shutter = shut_q && bias_ok;

  // dump sequencer
  typedef enum logic [2:0] {S_IDLE, S_PRE, S_SHIFT, S_POST, S_GAPL, S_READ} st_t;
  st_t           st;
  logic [TW-1:0] tmr;
  logic [NW-1:0] rem;
  logic [1:0]    halves;
  logic          gate_on;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      tmr    <= '0;
      rem    <= '0;
      halves <= '0;
    end else if (!bias_ok) begin
      st <= S_IDLE;
    end else begin
      unique case (st)
        S_IDLE: if (dump_go) begin
          halves <= dump_halves;
          rem    <= dump_lines;
          tmr    <= TW'(GAP - 1);
          st     <= (dump_lines == '0) ? S_READ : S_PRE;
        end
        S_PRE:
          if (tmr == '0) begin st <= S_SHIFT; tmr <= TW'(VSH - 1); end
          else tmr <= tmr - TW'(1);
        S_SHIFT:
          if (tmr == '0) begin st <= S_POST; tmr <= TW'(GAP - 1); end
          else tmr <= tmr - TW'(1);
        S_POST:
          if (tmr == '0) begin
            st  <= S_GAPL;
            tmr <= TW'(GAP - 1);
            rem <= rem - NW'(1);
          end else tmr <= tmr - TW'(1);
        S_GAPL:
          if (tmr == '0) begin
            st  <= (rem == '0) ? S_READ : S_PRE;
            tmr <= TW'(GAP - 1);
          end else tmr <= tmr - TW'(1);
        S_READ: st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  assign gate_on    = (st == S_PRE) || (st == S_SHIFT) || (st == S_POST);
  assign fdg_bot    = gate_on && halves[0] && bias_ok;
  assign fdg_top    = gate_on && halves[1] && bias_ok;
  assign vshift_req = (st == S_SHIFT) && (tmr == TW'(VSH - 1)) && bias_ok;
  assign read_line  = (st == S_READ) && bias_ok;

  // R4
  shut_bias_chk: assert property (@(posedge clk) disable iff (!rst_n)
    shutter |-> $past(bias_ok));
  // R3
  shut_armed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(shutter) |-> armed);
  // R5
  vshift_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vshift_req |-> (gate_on && $past(gate_on)));
  // R6
  read_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    read_line |=> !read_line && !gate_on);
endmodule

// File: tb/test_shutter_dump_ctrl.sv
module test_shutter_dump_ctrl;
  localparam int CW = 16, NW = 4, W = 5, G = 4, V = 3, P = 60;

  logic          clk = 1'b0, rst_n = 1'b0, bias_ok = 1'b0, frame_sync = 1'b0;
  logic [CW-1:0] frame_len = '0, exp_len = '0;
  logic          dump_go = 1'b0;
  logic [NW-1:0] dump_lines = '0;
  logic [1:0]    dump_halves = '0;
  logic          shutter, fdg_bot, fdg_top, vshift_req, read_line;
  int            n_run = 0, n_fail = 0;
  bit            done = 1'b0;

  always #5 clk = ~clk;

  shutter_dump_ctrl #(.CW(CW), .NW(NW), .SHUT_W(W), .GAP(G), .VSH(V)) i_shutter_dump_ctrl (
    .clk(clk), .rst_n(rst_n), .bias_ok(bias_ok), .frame_sync(frame_sync),
    .frame_len(frame_len), .exp_len(exp_len), .dump_go(dump_go),
    .dump_lines(dump_lines), .dump_halves(dump_halves), .shutter(shutter),
    .fdg_bot(fdg_bot), .fdg_top(fdg_top), .vshift_req(vshift_req), .read_line(read_line));

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic t_reset();
    #1;
    check({shutter, fdg_bot, fdg_top, vshift_req, read_line} == 5'b0,
          "R9 outputs low in reset",
          int'({shutter, fdg_bot, fdg_top, vshift_req, read_line}), 0);
  endtask

  task automatic t_shutter(input int e, input bit bias, input int exp_hi, input string tag);
    int hi = 0, last_hi = -1000;
    frame_len = CW'(P);
    exp_len   = CW'(e);
    bias_ok   = bias;
    for (int j = 0; j <= 2*P; j++) begin
      @(negedge clk);
      if (shutter) begin hi++; last_hi = j; end
      if (j == P || j == 2*P) begin
        check(hi == exp_hi, {tag, " pulse width"}, hi, exp_hi);
        if (exp_hi > 0) check(j - last_hi == e, {tag, " fall to sync"}, j - last_hi, e);
        hi = 0;
      end
      frame_sync = (j % P == 0) && (j < 2*P);
    end
    frame_sync = 1'b0;
    bias_ok = 1'b1;
  endtask

  task automatic t_dump(input int n, input logic [1:0] hv, input int abort_at,
                        input int e_bot, input int e_top, input int e_vs, input int e_rd,
                        input string tag);
    int bot = 0, top = 0, vs = 0, rd = 0, first_g = -1, first_v = -1, rd_at = -1;
    @(negedge clk);
    dump_go = 1'b1; dump_lines = NW'(n); dump_halves = hv;
    for (int j = 1; j <= n*(3*G+V) + 8; j++) begin
      @(negedge clk);
      dump_go = 1'b0;
      if (fdg_bot) begin bot++; if (first_g < 0) first_g = j; end
      if (fdg_top) top++;
      if (vshift_req) begin vs++; if (first_v < 0) first_v = j; end
      if (read_line) begin rd++; rd_at = j; end
      if (j == abort_at) bias_ok = 1'b0;
    end
    bias_ok = 1'b1;
    check(bot == e_bot, {tag, " R7 bottom gate cycles"}, bot, e_bot);
    check(top == e_top, {tag, " R7 top gate cycles"}, top, e_top);
    check(vs == e_vs, {tag, " R5 vshift count"}, vs, e_vs);
    check(rd == e_rd, {tag, " R6 read pulses"}, rd, e_rd);
    if (e_rd == 1)
      check(rd_at == n*(3*G+V) + 1, {tag, " R6 read position"}, rd_at, n*(3*G+V) + 1);
    if (n > 0 && hv[0] && abort_at < 0)
      check(first_v - first_g == G, {tag, " R5 gate lead"}, first_v - first_g, G);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_shutter(20, 1'b1, W, "R1 R2 mid exposure");
    t_shutter(0, 1'b1, W, "R1 zero exposure");
    t_shutter(P - W - 1, 1'b1, W, "R3 longest legal");
    t_shutter(P - W, 1'b1, 0, "R3 clamped");
    t_shutter(20, 1'b0, 0, "R4 bias low");
    t_dump(2, 2'b11, -1, 2*(2*G+V), 2*(2*G+V), 2, 1, "two lines both");
    t_dump(0, 2'b11, -1, 0, 0, 0, 1, "zero lines");
    t_dump(1, 2'b10, -1, 0, 2*G+V, 1, 1, "top only");
    t_dump(2, 2'b01, 6, 6, 0, 1, 0, "R8 abort");
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule